// File: doc/BRIEF.md
# Three-Compare One-Shot PWM Timer

This block is an up-counting timer that shapes one pulse per period. A period compare value sets where the counter wraps back to zero. A rise compare value and a fall compare value place the two edges of the pulse inside that period. Counting advances only on cycles where the count-enable tick is high and the run bit is set. The pulse output rests at a programmable idle level. The rise match drives it to the opposite level, and the fall match drives it back.

A one-shot bit makes the timer clear its own run bit at the period wrap. This gives a single delayed pulse per start command. A buffer-enable bit routes compare writes into shadow copies that move into the active compare values only at the period wrap, so a running waveform never sees a half-updated set. Each compare has a sticky match flag that software clears by writing 0 to its bit. Software reaches everything through a small register port with a synchronous write and a combinational read.

Top module: `pwm3_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0, the counter (address 1) reads 0, the flags (address 5) read 0, the output is 0, and the period (address 2), rise (address 3) and fall (address 4) compare values read all ones.
- R2: While control bit 0 (run) is 1, the counter goes up by one on each clock with the tick high and holds on clocks without it.
- R3: On a counting tick where the counter equals the period compare value, the counter goes to 0 and flag bit 0 is set.
- R4: A counting tick where the counter equals the rise value drives the output to the inverse of the idle level. One where it equals the fall value drives the output to the idle level. When both match on the same tick, the fall action wins.
- R5: Control bit 2 sets the idle level, and the output takes that level one clock after the timer is stopped.
- R6: With control bit 1 (one-shot) set, the period match clears the run bit, and the counter stays at 0 until software sets run again.
- R7: Clearing the run bit holds the counter at its value and returns the output to the idle level on the next clock.
- R8: With control bit 3 (buffer enable) set, compare writes go to shadow copies that become active at the next period match. With it clear, a compare write takes effect on the next clock.
- R9: Flags are set by hardware on the period (bit 0), rise (bit 1) and fall (bit 2) matches. A write to address 5 clears each flag whose data bit is 0 and leaves those written 1 unchanged.
- R10: A write to the counter address loads the counter only while run is 0, and has no effect while running.
- R11: Setting run after a one-shot stop resumes counting from the current counter value, with the output starting at the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-enable tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| pwm_out | output | 1 | Pulse output |

## Verification
A free-running waveform with distinct period, rise and fall positions shows that each comparator acts at its own count and that the counter wraps at the period. Moving both edges onto one count with the output already high separates fall-priority from rise-priority. Runs with the idle level high, with one-shot set, and with buffering enabled while a new period is written mid-cycle tell the variants apart from the plain mode. Writes to the counter and flags while running and while stopped distinguish the ignored cases from the accepted ones.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      ADR_CTRL   = 3'd0,
      ADR_COUNT  = 3'd1,
      ADR_PERIOD = 3'd2,
      ADR_RISE   = 3'd3,
      ADR_FALL   = 3'd4,
      ADR_FLAGS  = 3'd5
   } reg_addr_e;

   // compare slot index; slot k lives at ADR_PERIOD + k, flag bit k
   localparam int CMP_PER  = 0;
   localparam int CMP_RISE = 1;
   localparam int CMP_FALL = 2;
   localparam int NUM_CMP  = 3;

   localparam int CTL_W = 4;

   typedef struct packed {
      logic bufen;    // bit 3
      logic idle;     // bit 2
      logic oneshot;  // bit 1
      logic run;      // bit 0
   } ctl_t;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
   import pwm3_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [CNT_W-1:0]                wr_data,
   input  logic [NUM_CMP-1:0]              hit,
   output ctl_t                            ctl,
   output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp,
   output logic [NUM_CMP-1:0]              flags
);
   logic ctl_sel, flg_sel;
   assign ctl_sel = wr_en && (wr_addr == ADR_CTRL);
   assign flg_sel = wr_en && (wr_addr == ADR_FLAGS);

   // control: hardware one-shot stop takes priority over a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (ctl_sel)
            ctl <= ctl_t'(wr_data[CTL_W-1:0]);
         if (hit[CMP_PER] && ctl.oneshot)
            ctl.run <= 1'b0;
      end
   end

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(int'(ADR_PERIOD) + k);
      logic             sel;
      logic [CNT_W-1:0] act_q;
      assign sel    = wr_en && (wr_addr == SLOT_ADR);
      assign cmp[k] = act_q;

      // sticky flag: hardware set wins over software clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[k] <= 1'b0;
         else if (hit[k])
            flags[k] <= 1'b1;
         else if (flg_sel && !wr_data[k])
            flags[k] <= 1'b0;
      end

      if (HAS_BUF) begin : g_buf
         logic [CNT_W-1:0] shadow_q;
         // the shadow tracks every write so a transfer never loads stale data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shadow_q <= '1;
            else if (sel)
               shadow_q <= wr_data;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act_q <= '1;
            else if (hit[CMP_PER] && ctl.bufen)
               act_q <= shadow_q;
            else if (sel && !ctl.bufen)
               act_q <= wr_data;
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act_q <= '1;
            else if (sel)
               act_q <= wr_data;
         end
      end
   end
endmodule

// File: rtl/pwm3_count.sv
module pwm3_count
   import pwm3_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic                            run,
   input  logic                            load,
   input  logic [CNT_W-1:0]                load_val,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp,
   output logic [CNT_W-1:0]                cnt,
   output logic [NUM_CMP-1:0]              hit
);
   logic step;
   assign step = run && tick;

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_match
      assign hit[k] = step && (cnt == cmp[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (hit[CMP_PER])
         cnt <= '0;
      else if (step)
         cnt <= cnt + 1'b1;
      else if (load && !run)
         cnt <= load_val;
   end
endmodule

// File: rtl/pwm3_outgen.sv
module pwm3_outgen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic idle,
   input  logic hit_rise,
   input  logic hit_fall,
   output logic pwm
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pwm <= 1'b0;
      else if (!run)
         pwm <= idle;
      else if (hit_fall)
         pwm <= idle;
      else if (hit_rise)
         pwm <= ~idle;
   end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
   import pwm3_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_BUF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              pwm_out
);
   if (CNT_W < CTL_W || CNT_W > 32) begin : g_bad_width
      $error("pwm3_timer: CNT_W must lie in 4..32");
   end

   ctl_t                          ctl_w;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_w;
   logic [NUM_CMP-1:0]            flags_w;
   logic [NUM_CMP-1:0]            hit_w;
   logic [CNT_W-1:0]              cnt_q;
   logic                          cnt_load;

   assign cnt_load = wr_en && (wr_addr == ADR_COUNT);

   pwm3_regs #(.CNT_W(CNT_W), .HAS_BUF(HAS_BUF)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hit(hit_w), .ctl(ctl_w), .cmp(cmp_w),
      .flags(flags_w)
   );

   pwm3_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .run(ctl_w.run),
      .load(cnt_load), .load_val(wr_data), .cmp(cmp_w), .cnt(cnt_q),
      .hit(hit_w)
   );

   pwm3_outgen u_out (
      .clk(clk), .rst_n(rst_n), .run(ctl_w.run), .idle(ctl_w.idle),
      .hit_rise(hit_w[CMP_RISE]), .hit_fall(hit_w[CMP_FALL]), .pwm(pwm_out)
   );

   always_comb begin
      case (rd_addr)
         ADR_CTRL:   rd_data = CNT_W'(ctl_w);
         ADR_COUNT:  rd_data = cnt_q;
         ADR_PERIOD: rd_data = cmp_w[CMP_PER];
         ADR_RISE:   rd_data = cmp_w[CMP_RISE];
         ADR_FALL:   rd_data = cmp_w[CMP_FALL];
         ADR_FLAGS:  rd_data = CNT_W'(flags_w);
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/pwm3_checker.sv
module pwm3_checker
   import pwm3_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              run,
   input logic              oneshot,
   input logic              idle,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp_per,
   input logic [CNT_W-1:0]  cmp_fall,
   input logic [NUM_CMP-1:0] flags,
   input logic              pwm_out
);
   logic cnt_wr, flg_wr;
   assign cnt_wr = wr_en && (wr_addr == ADR_COUNT);
   assign flg_wr = wr_en && (wr_addr == ADR_FLAGS);

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt != cmp_per) |=> cnt == $past(cnt) + 1'b1);

   a_r3_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == cmp_per) |=> (cnt == '0) && flags[CMP_PER]);

   a_r4_fall_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == cmp_fall) |=> pwm_out == $past(idle));

   a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && oneshot && cnt == cmp_per) |=> !run);

   a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pwm_out == $past(idle));

   a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   a_r10_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));

   a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !flg_wr |=> (flags & $past(flags)) == $past(flags));
endmodule

bind pwm3_timer pwm3_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .run(ctl_w.run),
   .oneshot(ctl_w.oneshot), .idle(ctl_w.idle), .wr_en(wr_en),
   .wr_addr(wr_addr), .cnt(cnt_q), .cmp_per(cmp_w[pwm3_pkg::CMP_PER]),
   .cmp_fall(cmp_w[pwm3_pkg::CMP_FALL]), .flags(flags_w), .pwm_out(pwm_out)
);

// File: tb/sim_pwm3_timer.sv
module sim_pwm3_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        pwm_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_CTL = 3'd0, A_CNT = 3'd1, A_PER = 3'd2,
                          A_RISE = 3'd3, A_FALL = 3'd4, A_FLG = 3'd5;

   always #10 clk = ~clk;

   pwm3_timer u0 (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk); cnt_tick = 1'b1;
         @(negedge clk); cnt_tick = 1'b0;
      end
   endtask

   task automatic idle_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a,
                          input logic [15:0] exp);
      rd_addr = a;
      #1;
      check(req, $sformatf("reg %0d", a), rd_data, exp);
   endtask

   task automatic chk_out(input string req, input logic exp);
      check(req, "pwm_out", {15'd0, pwm_out}, {15'd0, exp});
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic t_reset;
      chk_reg("R1", A_CTL, 16'h0);
      chk_reg("R1", A_CNT, 16'h0);
      chk_reg("R1", A_FLG, 16'h0);
      chk_reg("R1", A_PER, 16'hFFFF);
      chk_reg("R1", A_FALL, 16'hFFFF);
      chk_out("R1", 1'b0);
   endtask

   task automatic t_run_basic;
      wr(A_PER, 16'd5);
      chk_reg("R8", A_PER, 16'd5);          // R8 immediate when unbuffered
      wr(A_RISE, 16'd2);
      wr(A_FALL, 16'd4);
      wr(A_CTL, 16'h1);
      tick(1);
      chk_reg("R2", A_CNT, 16'd1);
      idle_cyc(3);
      chk_reg("R2", A_CNT, 16'd1);          // R2 hold without tick
      tick(2);
      chk_reg("R2", A_CNT, 16'd3);
      chk_out("R4", 1'b1);                  // R4 rise at count 2
      tick(2);
      chk_out("R4", 1'b0);                  // R4 fall at count 4
      chk_reg("R9", A_FLG, 16'h6);
      tick(1);
      chk_reg("R3", A_CNT, 16'd0);
      chk_reg("R3", A_FLG, 16'h7);
   endtask

   task automatic t_flags;
      wr(A_FLG, 16'h5);
      chk_reg("R9", A_FLG, 16'h5);
      wr(A_FLG, 16'h7);
      chk_reg("R9", A_FLG, 16'h5);          // R9 writing 1 has no effect
      wr(A_FLG, 16'h0);
      chk_reg("R9", A_FLG, 16'h0);
   endtask

   task automatic t_stop_and_load;
      tick(3);
      chk_out("R4", 1'b1);
      wr(A_CNT, 16'h12);
      chk_reg("R10", A_CNT, 16'd3);         // R10 ignored while running
      wr(A_CTL, 16'h0);
      idle_cyc(1);
      chk_out("R7", 1'b0);
      tick(2);
      chk_reg("R7", A_CNT, 16'd3);
      wr(A_CNT, 16'h0);
      chk_reg("R10", A_CNT, 16'd0);
   endtask

   task automatic t_idle_level;
      wr(A_CTL, 16'h4);
      idle_cyc(1);
      chk_out("R5", 1'b1);
      wr(A_CTL, 16'h5);
      tick(3);
      chk_out("R5", 1'b0);                  // R5 rise drives inverse of idle
      tick(2);
      chk_out("R5", 1'b1);
      wr(A_CTL, 16'h0);
      idle_cyc(1);
      chk_out("R5", 1'b0);
      wr(A_CNT, 16'h0);
   endtask

   task automatic t_tie;
      wr(A_PER, 16'd6);
      wr(A_RISE, 16'd1);
      wr(A_FALL, 16'd5);
      wr(A_CTL, 16'h1);
      tick(2);
      chk_out("R4", 1'b1);
      wr(A_RISE, 16'd3);
      wr(A_FALL, 16'd3);
      tick(2);
      chk_reg("R4", A_CNT, 16'd4);
      chk_out("R4", 1'b0);                  // R4 fall wins a tie
      wr(A_CTL, 16'h0);
      wr(A_CNT, 16'h0);
   endtask

   task automatic t_oneshot;
      wr(A_PER, 16'd3);
      wr(A_RISE, 16'd1);
      wr(A_FALL, 16'd2);
      wr(A_FLG, 16'h0);
      wr(A_CTL, 16'h3);
      tick(4);
      chk_reg("R6", A_CNT, 16'd0);
      chk_reg("R6", A_CTL, 16'h2);
      chk_reg("R6", A_FLG, 16'h7);
      tick(2);
      chk_reg("R6", A_CNT, 16'd0);
      chk_out("R6", 1'b0);
      wr(A_CTL, 16'h3);
      idle_cyc(1);
      chk_out("R11", 1'b0);
      tick(1);
      chk_reg("R11", A_CNT, 16'd1);
      tick(1);
      chk_out("R11", 1'b1);
      chk_reg("R11", A_CNT, 16'd2);
      tick(2);
      chk_reg("R11", A_CTL, 16'h2);
   endtask

   task automatic t_buffered;
      wr(A_CTL, 16'h0);
      wr(A_CNT, 16'h0);
      wr(A_PER, 16'd4);
      wr(A_CTL, 16'h9);
      wr(A_PER, 16'd2);
      chk_reg("R8", A_PER, 16'd4);          // R8 held in shadow
      tick(4);
      chk_reg("R8", A_CNT, 16'd4);
      chk_reg("R8", A_PER, 16'd4);
      tick(1);
      chk_reg("R8", A_PER, 16'd2);          // R8 transferred at period match
      tick(3);
      chk_reg("R8", A_CNT, 16'd0);
      wr(A_CTL, 16'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle_cyc(3);
      rst_n = 1'b1;
      idle_cyc(1);
      t_reset();
      t_run_basic();
      t_flags();
      t_stop_and_load();
      t_idle_level();
      t_tie();
      t_oneshot();
      t_buffered();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule